// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block decides, once per instruction, whether the processor core should leave its program for a service routine, and where that routine starts. It watches five hardware request lines and a software restart strobe. The hardware lines are one critical line that cannot be blocked, three restart-numbered lines with individual masks, and one external line whose device supplies its own start address. When a request wins, the block raises `take` for one cycle together with a 16-bit start address.

The core reports instruction ends on `boundary`. It pulses `en_cmd`, `dis_cmd` or `mask_wr` when it executes the enable, disable or set-mask instructions. It pulses `sw_req` with a restart number when it executes a software restart. Hardware requests are only considered on a boundary cycle. A software restart is acted on in the cycle it is signalled. The decision is registered, so `take`, `vec_addr` and `ext_ack` appear in the cycle after the deciding edge.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `take` and `ext_ack` are 0, the enable flag is clear and all three masks are set (1 = masked), so no maskable request is taken until both are changed.
- R2: `sw_req` with number n gives `take`=1 and `vec_addr`=8·n in the next cycle. It needs neither `boundary` nor the enable flag, and it wins over every hardware request in the same cycle.
- R3: `crit_req` high on a boundary cycle gives `take` with `vec_addr`=0x0024, whatever the enable flag and masks hold.
- R4: Among hardware requests seen on the same boundary, the order from highest to lowest is `crit_req`, `hv_req[2]`, `hv_req[1]`, `hv_req[0]`, `ext_req`.
- R5: The three restart-numbered lines vector as follows: `hv_req[2]` to 0x003C, `hv_req[1]` to 0x0034, `hv_req[0]` to 0x002C.
- R6: A rising edge on `hv_req[2]` is held in a pending latch until it is serviced. Servicing clears the latch, so a line held high is serviced once per edge.
- R7: `hv_req[1]` and `hv_req[0]` are level-sensitive. A request that drops before a boundary is not remembered.
- R8: On `mask_wr`, if `mask_data[3]`=1 then `mask_data[2:0]` loads the masks for `hv_req[2:0]` (1 = masked), and otherwise the masks are unchanged. `mask_data[4]`=1 clears the `hv_req[2]` pending latch. A masked edge stays pending.
- R9: `en_cmd` sets the enable flag, but no maskable request is taken on the boundary that ends the enabling instruction. Requests are taken from the boundary that ends the following instruction onward. `en_cmd` may arrive in any cycle of that instruction up to and including its boundary cycle.
- R10: `dis_cmd` and reset clear the enable flag. `dis_cmd` wins over a simultaneous `en_cmd` and blocks maskable acceptance in its own cycle.
- R11: Accepting any hardware request, `crit_req` included, clears the enable flag. A software restart does not.
- R12: When `ext_req` is accepted, `ext_ack` and `take` rise together and `vec_addr` equals `ext_addr` sampled at the accepting edge.
- R13: Without `boundary` (and without `sw_req`) no request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crit_req | input | 1 | Non-maskable request, level |
| hv_req | input | 3 | Restart-numbered requests: [2] edge, [1],[0] level |
| ext_req | input | 1 | Non-vectored request, level |
| ext_addr | input | 16 | Start address supplied by the external device |
| sw_req | input | 1 | Software restart executed this cycle |
| sw_num | input | 3 | Software restart number |
| boundary | input | 1 | Last cycle of an instruction |
| en_cmd | input | 1 | Enable-instruction pulse |
| dis_cmd | input | 1 | Disable-instruction pulse |
| mask_wr | input | 1 | Set-mask instruction pulse |
| mask_data | input | 5 | Set-mask operand: [2:0] masks, [3] load gate, [4] clear edge latch |
| take | output | 1 | Interrupt taken, one-cycle strobe |
| vec_addr | output | 16 | Start address, valid while `take` is 1, otherwise 0 |
| ext_ack | output | 1 | Acknowledge to the external device |

## Verification
The sharpest case is the one-instruction enable delay. A design that honours `en_cmd` immediately takes a pending level request one boundary early. A design that counts boundaries wrongly when `en_cmd` arrives before its boundary takes it one instruction late. The edge latch is tested held high across two services. A level copy of it would fire twice, and a latch that is not cleared would fire again after the next enable. The mask load gate, the latch-clear bit and a masked edge that must survive until unmasked are each tested in isolation, along with the full five-way priority ladder and a software restart colliding with the critical line. Random stimulus then crosses commands with boundaries, where ordering slips between disable, acceptance and enable would show up.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    // restart numbers of the fixed hardware sources (vector = num*stride + stride/2)
    localparam int unsigned IRQV_CRIT_NUM = 4;
    localparam int unsigned IRQV_E2_NUM   = 7;
    localparam int unsigned IRQV_L1_NUM   = 6;
    localparam int unsigned IRQV_L0_NUM   = 5;

    // grant positions, index 0 is highest priority
    localparam int unsigned G_SW   = 0;
    localparam int unsigned G_CRIT = 1;
    localparam int unsigned G_E2   = 2;
    localparam int unsigned G_L1   = 3;
    localparam int unsigned G_L0   = 4;
    localparam int unsigned G_EXT  = 5;
    localparam int unsigned IRQV_NSRC = 6;

    // set-mask operand fields
    localparam int unsigned MB_GATE = 3;
    localparam int unsigned MB_CLR  = 4;
    localparam int unsigned MB_W    = MB_CLR + 1;

    typedef struct packed {
        logic       ie;
        logic       skip;
        logic [2:0] mask;
        logic       take;
        logic       ack;
    } irqv_st_t;

    localparam irqv_st_t IRQV_ST_RST = '{ie: 1'b0, skip: 1'b0, mask: 3'b111,
                                         take: 1'b0, ack: 1'b0};

endpackage

// File: rtl/irqv_edge_cap.sv
module irqv_edge_cap (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic clr,
    output logic pend
);
    logic prev_d, prev_q;
    logic pend_d, pend_q;

    always_comb begin
        prev_d = req;
        // a fresh edge wins over a clear in the same cycle
        pend_d = (req & ~prev_q) | (pend_q & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/irqv_pick.sv
module irqv_pick #(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    assign gnt[0] = req[0];
    for (genvar i = 1; i < N; i++) begin : g_chain
        assign gnt[i] = req[i] & ~(|req[i-1:0]);
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int unsigned VEC_W      = 16,
    parameter int unsigned VEC_STRIDE = 8,
    parameter int unsigned SW_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crit_req,
    input  logic [2:0]       hv_req,
    input  logic             ext_req,
    input  logic [VEC_W-1:0] ext_addr,
    input  logic             sw_req,
    input  logic [SW_W-1:0]  sw_num,
    input  logic             boundary,
    input  logic             en_cmd,
    input  logic             dis_cmd,
    input  logic             mask_wr,
    input  logic [MB_W-1:0]  mask_data,
    output logic             take,
    output logic [VEC_W-1:0] vec_addr,
    output logic             ext_ack
);
    localparam int unsigned HALF = VEC_STRIDE / 2;
    localparam logic [VEC_W-1:0] V_CRIT = VEC_W'(IRQV_CRIT_NUM * VEC_STRIDE + HALF);
    localparam logic [VEC_W-1:0] V_E2   = VEC_W'(IRQV_E2_NUM   * VEC_STRIDE + HALF);
    localparam logic [VEC_W-1:0] V_L1   = VEC_W'(IRQV_L1_NUM   * VEC_STRIDE + HALF);
    localparam logic [VEC_W-1:0] V_L0   = VEC_W'(IRQV_L0_NUM   * VEC_STRIDE + HALF);

    irqv_st_t             st_d, st_q;
    logic [VEC_W-1:0]     vec_d, vec_q;
    logic [IRQV_NSRC-1:0] req_v, gnt_v;
    logic                 e2_pend, e2_clr, ie_ok, hw_acc;

    irqv_edge_cap u_e2 (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (hv_req[2]),
        .clr  (e2_clr),
        .pend (e2_pend)
    );

    irqv_pick #(.N(IRQV_NSRC)) u_pick (
        .req(req_v),
        .gnt(gnt_v)
    );

    always_comb begin
        // maskable sources need the flag and no pending block this cycle
        ie_ok = st_q.ie & ~en_cmd & ~dis_cmd & ~st_q.skip;

        req_v         = '0;
        req_v[G_SW]   = sw_req;
        req_v[G_CRIT] = boundary & crit_req;
        req_v[G_E2]   = boundary & ie_ok & e2_pend   & ~st_q.mask[2];
        req_v[G_L1]   = boundary & ie_ok & hv_req[1] & ~st_q.mask[1];
        req_v[G_L0]   = boundary & ie_ok & hv_req[0] & ~st_q.mask[0];
        req_v[G_EXT]  = boundary & ie_ok & ext_req;

        hw_acc = |gnt_v[IRQV_NSRC-1:1];
        e2_clr = gnt_v[G_E2] | (mask_wr & mask_data[MB_CLR]);

        st_d      = st_q;
        st_d.take = |gnt_v;
        st_d.ack  = gnt_v[G_EXT];

        if (gnt_v[G_SW])        vec_d = VEC_W'(sw_num) * VEC_W'(VEC_STRIDE);
        else if (gnt_v[G_CRIT]) vec_d = V_CRIT;
        else if (gnt_v[G_E2])   vec_d = V_E2;
        else if (gnt_v[G_L1])   vec_d = V_L1;
        else if (gnt_v[G_L0])   vec_d = V_L0;
        else if (gnt_v[G_EXT])  vec_d = ext_addr;
        else                    vec_d = '0;

        // flag: disable or acceptance clear, enable sets
        if (dis_cmd || hw_acc) st_d.ie = 1'b0;
        else if (en_cmd)       st_d.ie = 1'b1;

        // skip marks the boundary that ends the enabling instruction
        if (dis_cmd)       st_d.skip = 1'b0;
        else if (en_cmd)   st_d.skip = ~boundary;
        else if (boundary) st_d.skip = 1'b0;

        if (mask_wr && mask_data[MB_GATE]) st_d.mask = mask_data[2:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= IRQV_ST_RST;
            vec_q <= '0;
        end else begin
            st_q  <= st_d;
            vec_q <= vec_d;
        end
    end

    assign take     = st_q.take;
    assign ext_ack  = st_q.ack;
    assign vec_addr = vec_q;
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk
    import irqv_pkg::*;
#(
    parameter int unsigned VEC_W      = 16,
    parameter int unsigned VEC_STRIDE = 8,
    parameter int unsigned SW_W       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             crit_req,
    input logic             boundary,
    input logic             sw_req,
    input logic [SW_W-1:0]  sw_num,
    input logic             dis_cmd,
    input logic [VEC_W-1:0] ext_addr,
    input logic             take,
    input logic [VEC_W-1:0] vec_addr,
    input logic             ext_ack
);
    localparam logic [VEC_W-1:0] V_CRIT = VEC_W'(IRQV_CRIT_NUM * VEC_STRIDE + VEC_STRIDE / 2);

    p_sw_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |=> take && vec_addr == VEC_W'(VEC_W'($past(sw_num)) * VEC_W'(VEC_STRIDE)));

    p_crit_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_req && boundary && !sw_req) |=> take && vec_addr == V_CRIT);

    p_dis_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_cmd && boundary && !crit_req && !sw_req) |=> !take);

    p_ack_with_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ack |-> take);

    p_ack_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !sw_req && !crit_req) |=> (!ext_ack || vec_addr == $past(ext_addr)));

    p_needs_boundary_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !sw_req) |=> !take);
endmodule

bind irq_vector_ctrl irqv_chk #(
    .VEC_W(VEC_W), .VEC_STRIDE(VEC_STRIDE), .SW_W(SW_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .boundary(boundary),
    .sw_req(sw_req), .sw_num(sw_num), .dis_cmd(dis_cmd), .ext_addr(ext_addr),
    .take(take), .vec_addr(vec_addr), .ext_ack(ext_ack)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crit = 0, ext = 0, sw = 0, bnd = 0, en = 0, dis = 0, mw = 0;
    logic [2:0]  hv = '0, swn = '0;
    logic [15:0] eaddr = '0;
    logic [4:0]  mb = '0;
    logic        take, ack;
    logic [15:0] vec;

    int checks = 0, failures = 0;

    // reference state
    logic       m_ie, m_skip, m_latch, m_prev;
    logic [2:0] m_mask;

    always #(CLK_NS/2) clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .crit_req(crit), .hv_req(hv), .ext_req(ext),
        .ext_addr(eaddr), .sw_req(sw), .sw_num(swn), .boundary(bnd),
        .en_cmd(en), .dis_cmd(dis), .mask_wr(mw), .mask_data(mb),
        .take(take), .vec_addr(vec), .ext_ack(ack)
    );

    task automatic model_reset();
        m_ie = 0; m_skip = 0; m_latch = 0; m_prev = 0; m_mask = 3'b111;
    endtask

    task automatic lit(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick(input string tag);
        logic        ieok, e_take, e_ack, hw, c_e2;
        logic [15:0] e_vec;
        ieok = m_ie & !en & !dis & !m_skip;
        e_take = 0; e_ack = 0; e_vec = '0; hw = 0; c_e2 = 0;
        if (sw) begin e_take = 1; e_vec = {10'b0, swn, 3'b000}; end
        else if (bnd && crit) begin e_take = 1; e_vec = 16'h0024; hw = 1; end
        else if (bnd && ieok && m_latch && !m_mask[2]) begin
            e_take = 1; e_vec = 16'h003C; hw = 1; c_e2 = 1; end
        else if (bnd && ieok && hv[1] && !m_mask[1]) begin e_take = 1; e_vec = 16'h0034; hw = 1; end
        else if (bnd && ieok && hv[0] && !m_mask[0]) begin e_take = 1; e_vec = 16'h002C; hw = 1; end
        else if (bnd && ieok && ext) begin e_take = 1; e_vec = eaddr; e_ack = 1; hw = 1; end
        @(posedge clk); #1;
        checks++;
        if (take !== e_take || vec !== e_vec || ack !== e_ack) begin
            failures++;
            $display("FAIL %s take=%b vec=%h ack=%b expected take=%b vec=%h ack=%b",
                     tag, take, vec, ack, e_take, e_vec, e_ack);
        end
        m_latch = (hv[2] & !m_prev) | (m_latch & !c_e2 & !(mw & mb[4]));
        m_prev  = hv[2];
        if (mw && mb[3]) m_mask = mb[2:0];
        m_skip  = dis ? 1'b0 : en ? !bnd : bnd ? 1'b0 : m_skip;
        m_ie    = (dis || hw) ? 1'b0 : en ? 1'b1 : m_ie;
        @(negedge clk);
        sw = 0; bnd = 0; en = 0; dis = 0; mw = 0;
    endtask

    task automatic enable_ie();
        en = 1; bnd = 1; tick("R9");
        bnd = 1; tick("R9");
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    initial begin
        #(CLK_NS * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        do_reset();
        // R1: idle after reset, masks set
        tick("R1"); lit("R1 take", {15'b0, take}, 16'h0);
        enable_ie(); hv = 3'b010; bnd = 1; tick("R1"); lit("R1 masked", {15'b0, take}, 16'h0);
        // R8: gate bit low leaves masks
        mw = 1; mb = 5'b00000; tick("R8"); bnd = 1; tick("R8"); lit("R8 gate", {15'b0, take}, 16'h0);
        mw = 1; mb = 5'b01000; tick("R8"); bnd = 1; tick("R5");
        lit("R5 l1 vec", vec, 16'h0034);
        // R11: acceptance cleared the flag
        bnd = 1; tick("R11"); lit("R11 cleared", {15'b0, take}, 16'h0);
        hv = 3'b000;
        // R9: enable delay, command on boundary
        hv = 3'b001; en = 1; bnd = 1; tick("R9"); lit("R9 same", {15'b0, take}, 16'h0);
        bnd = 1; tick("R9"); lit("R9 next", vec, 16'h002C);
        // R9: command before boundary
        en = 1; tick("R9"); bnd = 1; tick("R9"); lit("R9 own end", {15'b0, take}, 16'h0);
        bnd = 1; tick("R9"); lit("R9 following", vec, 16'h002C);
        hv = 3'b000;
        // R6: edge latch held after drop, once per edge
        enable_ie(); hv = 3'b100; tick("R6"); hv = 3'b000; tick("R6");
        bnd = 1; tick("R6"); lit("R6 latched", vec, 16'h003C);
        enable_ie(); lit("R6 cleared", {15'b0, take}, 16'h0);
        hv = 3'b100; tick("R6"); enable_ie(); lit("R6 held", vec, 16'h003C);
        enable_ie(); lit("R6 no refire", {15'b0, take}, 16'h0);
        hv = 3'b000;
        // R8: clear bit drops latch
        hv = 3'b100; tick("R8"); hv = 3'b000; mw = 1; mb = 5'b10000; tick("R8");
        enable_ie(); lit("R8 clr", {15'b0, take}, 16'h0);
        // R8: masked edge stays pending
        mw = 1; mb = 5'b01100; tick("R8"); hv = 3'b100; tick("R8"); hv = 3'b000;
        enable_ie(); lit("R8 masked", {15'b0, take}, 16'h0);
        mw = 1; mb = 5'b01000; tick("R8"); bnd = 1; tick("R8");
        lit("R8 unmasked", vec, 16'h003C);
        // R7: level not remembered
        enable_ie(); hv = 3'b010; tick("R7"); hv = 3'b000; bnd = 1; tick("R7");
        lit("R7 dropped", {15'b0, take}, 16'h0);
        // R4: priority ladder
        enable_ie();
        hv = 3'b111; ext = 1; eaddr = 16'hBEEF; crit = 1; bnd = 1; tick("R4");
        lit("R4 crit", vec, 16'h0024); crit = 0;
        enable_ie(); lit("R4 e2", vec, 16'h003C);
        enable_ie(); lit("R4 l1", vec, 16'h0034);
        hv = 3'b001; enable_ie(); lit("R4 l0", vec, 16'h002C);
        hv = 3'b000; enable_ie(); lit("R12 addr", vec, 16'hBEEF);
        lit("R12 ack", {15'b0, ack}, 16'h1);
        ext = 0;
        // R3 / R13: critical line ignores mask and flag, needs boundary
        mw = 1; mb = 5'b01111; tick("R3");
        crit = 1; tick("R13"); lit("R13 no bnd", {15'b0, take}, 16'h0);
        bnd = 1; tick("R3"); lit("R3 vec", vec, 16'h0024); crit = 0;
        // R2: software restarts
        for (int n = 0; n < 8; n++) begin
            sw = 1; swn = 3'(n); tick("R2"); lit("R2 vec", vec, 16'(n * 8));
        end
        crit = 1; bnd = 1; sw = 1; swn = 3'd5; tick("R2"); lit("R2 wins", vec, 16'h0028);
        crit = 0;
        // R10: disable, disable beats enable, reset
        mw = 1; mb = 5'b01000; tick("R10"); enable_ie();
        ext = 1; eaddr = 16'h1234; dis = 1; bnd = 1; tick("R10");
        lit("R10 dis", {15'b0, take}, 16'h0);
        bnd = 1; tick("R10"); lit("R10 cleared", {15'b0, take}, 16'h0);
        en = 1; dis = 1; bnd = 1; tick("R10"); bnd = 1; tick("R10");
        lit("R10 dis wins", {15'b0, take}, 16'h0);
        ext = 0; enable_ie(); do_reset();
        ext = 1; bnd = 1; tick("R10"); lit("R10 reset", {15'b0, take}, 16'h0);
        ext = 0; tick("R10");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            bnd = ($urandom % 3) == 0;
            crit = ($urandom % 16) == 0;
            if (($urandom % 4) == 0) hv = 3'($urandom);
            ext = ($urandom % 6) == 0;
            eaddr = 16'($urandom);
            sw = ($urandom % 20) == 0;
            swn = 3'($urandom);
            en = ($urandom % 8) == 0;
            dis = ($urandom % 16) == 0;
            mw = ($urandom % 16) == 0;
            mb = 5'($urandom);
            tick("R4");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule